// File: doc/BRIEF.md
# Grouped Pulse-Width Modulation Generator

This block drives sixteen pulse-width modulated outputs organised as four groups of four. Each group owns one counter, one period value, one alignment choice (edge or center) and one duty value per output. Within a group, outputs are handled as two pairs: a pair either carries two independent waveforms, each from its own duty, or two complementary waveforms derived from the duty of the pair's even output.

Configuration arrives through a plain write port. Period, duty, alignment and pairing writes land in shadow registers and are copied to the working set only when the group's counter crosses into a new period, so a running waveform never shows a partial or glitched pulse. The enable bit acts at once: a disabled group sits with its counter at zero and all four outputs low, and its working set follows the shadow registers directly, so the first period after enabling already uses the written values.

The write port carries control writes, not a data stream, so it has no handshake: a write with `wr_en` high is accepted on every rising clock edge.

Top module: `pwm_grouped_gen`

## Requirements
- R1: Address bits [4:3] of `wr_addr` pick the group g and bits [2:0] pick the register: 0 = period, 1 = control, 2..5 = duty of output 0..3; output i of group g appears on `pwm_out[4*g+i]`, and writes to one group leave the others untouched.
- R2: With control bit 1 clear (edge alignment) the group counter runs 0, 1, ..., P-1 and wraps, so one period is P cycles, and an output is high in the first d cycles of each period (count below d).
- R3: With control bit 1 set (center alignment) the counter runs 0 up to P and back down to 1, so one period is 2P cycles, and an output is high while the count is below d, giving 2d-1 high cycles centred on count 0.
- R4: A duty of 0 keeps its output low for the whole period; a duty equal to or above the period keeps it high for the whole period.
- R5: Control bit 2 (pair 0: outputs 0 and 1) or bit 3 (pair 1: outputs 2 and 3) set makes the odd output the inverse of the even output, both derived from the even output's duty.
- R6: With the pair's control bit clear, each output of the pair follows its own duty register.
- R7: Period, duty, alignment and pairing writes made while a group runs take effect at the first cycle of the next period; the current period finishes with the old values.
- R8: Control bit 0 clear disables the group at once: its counter is held at 0 and its four outputs are low; after it is set again, the first cycle of the group has count 0.
- R9: After reset every group is disabled and all sixteen outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 5 | Group index (bits 4:3) and register select (bits 2:0) |
| wr_data | input | 8 | Write data: period, duty or control bits |
| pwm_out | output | 16 | Modulated outputs, four per group |

## Verification
On every cycle the assertions hold the counter of each group inside its legal range for the selected alignment, keep a disabled counter at zero, and keep the working period and duty values still between period boundaries. What the outputs look like, the number of high cycles per period, the centred shape in center mode, complement pairing, the exact period at which a mid-period write takes hold and the restart at count zero after re-enabling, can only be shown by the bench's scenarios sampling the output pins.

// File: rtl/pwm_grp_pkg.sv
package pwm_grp_pkg;

  // Register select values inside one group (wr_addr low bits).
  localparam int SEL_W          = 3;
  localparam int REG_PERIOD     = 0;
  localparam int REG_CTRL       = 1;
  localparam int REG_DUTY_BASE  = 2;

  // Control register bit positions.
  localparam int CTRL_EN_BIT    = 0;
  localparam int CTRL_ALIGN_BIT = 1;
  localparam int CTRL_PAIR_BIT0 = 2;

  typedef enum logic {
    ALIGN_EDGE   = 1'b0,
    ALIGN_CENTER = 1'b1
  } align_e;

endpackage

// File: rtl/pwm_grp_regs.sv
module pwm_grp_regs
  import pwm_grp_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int NOUT  = 4,
  localparam int NPAIR = NOUT / 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_stb,
  input  logic [SEL_W-1:0]               wr_sel,
  input  logic [CNT_W-1:0]               wr_data,
  input  logic                           period_end,
  output logic                           en_o,
  output align_e                         align_o,
  output logic [CNT_W-1:0]               period_o,
  output logic [NPAIR-1:0]               comp_o,
  output logic [NOUT-1:0][CNT_W-1:0]     duty_o
);

  logic                       en_q;
  align_e                     sh_align_q, sh_align_d, act_align_q;
  logic [CNT_W-1:0]           sh_period_q, sh_period_d, act_period_q;
  logic [NPAIR-1:0]           sh_comp_q, sh_comp_d, act_comp_q;
  logic [NOUT-1:0][CNT_W-1:0] sh_duty_q, sh_duty_d, act_duty_q;
  logic                       ctrl_wr;
  logic                       take_shadow;

  assign ctrl_wr     = wr_stb && (int'(wr_sel) == REG_CTRL);
  // A stopped group tracks its shadow set so enabling starts clean.
  assign take_shadow = period_end || !en_q;

  always_comb begin
    sh_period_d = sh_period_q;
    sh_align_d  = sh_align_q;
    sh_comp_d   = sh_comp_q;
    sh_duty_d   = sh_duty_q;
    if (wr_stb && (int'(wr_sel) == REG_PERIOD)) sh_period_d = wr_data;
    if (ctrl_wr) begin
      sh_align_d = align_e'(wr_data[CTRL_ALIGN_BIT]);
      for (int p = 0; p < NPAIR; p++) sh_comp_d[p] = wr_data[CTRL_PAIR_BIT0 + p];
    end
    for (int i = 0; i < NOUT; i++)
      if (wr_stb && (int'(wr_sel) == REG_DUTY_BASE + i)) sh_duty_d[i] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q         <= 1'b0;
      sh_period_q  <= '0;
      sh_align_q   <= ALIGN_EDGE;
      sh_comp_q    <= '0;
      sh_duty_q    <= '0;
      act_period_q <= '0;
      act_align_q  <= ALIGN_EDGE;
      act_comp_q   <= '0;
      act_duty_q   <= '0;
    end else begin
      if (ctrl_wr) en_q <= wr_data[CTRL_EN_BIT];
      sh_period_q <= sh_period_d;
      sh_align_q  <= sh_align_d;
      sh_comp_q   <= sh_comp_d;
      sh_duty_q   <= sh_duty_d;
      if (take_shadow) begin
        act_period_q <= sh_period_d;
        act_align_q  <= sh_align_d;
        act_comp_q   <= sh_comp_d;
        act_duty_q   <= sh_duty_d;
      end
    end
  end

  assign en_o     = en_q;
  assign align_o  = act_align_q;
  assign period_o = act_period_q;
  assign comp_o   = act_comp_q;
  assign duty_o   = act_duty_q;

  // R7: inside a running period the working set does not move.
  assert_active_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !period_end) |=> ($stable(act_duty_q) && $stable(act_period_q)
                               && $stable(act_comp_q) && $stable(act_align_q)));

endmodule

// File: rtl/pwm_grp_timer.sv
module pwm_grp_timer
  import pwm_grp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  align_e           align,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt_o,
  output logic             period_end_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;
  logic [CNT_W:0]   cnt_inc;
  logic             wrap;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    wrap  = 1'b0;
    if (!en) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (align == ALIGN_EDGE) begin
      up_d = 1'b1;
      if (cnt_inc >= {1'b0, period}) begin
        cnt_d = '0;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end else if (up_q) begin
      if (cnt_q >= period) begin
        if (period <= CNT_W'(1)) begin
          cnt_d = '0;
          wrap  = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
          up_d  = 1'b0;
        end
      end else begin
        cnt_d = cnt_inc[CNT_W-1:0];
      end
    end else begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d = '0;
        up_d  = 1'b1;
        wrap  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt_o        = cnt_q;
  assign period_end_o = wrap;

  // R8: a stopped group restarts from zero.
  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0));

  // R2: edge alignment never reaches the period value.
  assert_edge_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && align == ALIGN_EDGE) |-> (cnt_q < period || cnt_q == '0));

  // R3: center alignment turns at the period value.
  assert_center_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && align == ALIGN_CENTER) |-> (cnt_q <= period));

endmodule

// File: rtl/pwm_grp_out.sv
module pwm_grp_out #(
  parameter int CNT_W = 8,
  parameter int NOUT  = 4,
  localparam int NPAIR = NOUT / 2
) (
  input  logic                       en,
  input  logic [CNT_W-1:0]           cnt,
  input  logic [CNT_W-1:0]           period,
  input  logic [NPAIR-1:0]           comp,
  input  logic [NOUT-1:0][CNT_W-1:0] duty,
  output logic [NOUT-1:0]            out_o
);

  logic [NOUT-1:0] level;

  for (genvar i = 0; i < NOUT; i++) begin : g_cmp
    assign level[i] = (duty[i] != '0) && ((cnt < duty[i]) || (duty[i] >= period));
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign out_o[2*p]   = en & level[2*p];
    assign out_o[2*p+1] = en & (comp[p] ? ~level[2*p] : level[2*p+1]);
  end

endmodule

// File: rtl/pwm_grouped_gen.sv
module pwm_grouped_gen
  import pwm_grp_pkg::*;
#(
  parameter int NUM_GRP     = 4,
  parameter int OUT_PER_GRP = 4,
  parameter int CNT_W       = 8,
  localparam int GRP_W      = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int ADDR_W     = GRP_W + SEL_W,
  localparam int NUM_OUT    = NUM_GRP * OUT_PER_GRP
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  output logic [NUM_OUT-1:0] pwm_out
);

  localparam int NPAIR = OUT_PER_GRP / 2;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic                              stb;
    logic                              en;
    align_e                            align;
    logic [CNT_W-1:0]                  period;
    logic [NPAIR-1:0]                  comp;
    logic [OUT_PER_GRP-1:0][CNT_W-1:0] duty;
    logic [CNT_W-1:0]                  cnt;
    logic                              period_end;

    assign stb = wr_en && (wr_addr[ADDR_W-1:SEL_W] == GRP_W'(g));

    pwm_grp_regs #(.CNT_W(CNT_W), .NOUT(OUT_PER_GRP)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_stb     (stb),
      .wr_sel     (wr_addr[SEL_W-1:0]),
      .wr_data    (wr_data),
      .period_end (period_end),
      .en_o       (en),
      .align_o    (align),
      .period_o   (period),
      .comp_o     (comp),
      .duty_o     (duty)
    );

    pwm_grp_timer #(.CNT_W(CNT_W)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (en),
      .align        (align),
      .period       (period),
      .cnt_o        (cnt),
      .period_end_o (period_end)
    );

    pwm_grp_out #(.CNT_W(CNT_W), .NOUT(OUT_PER_GRP)) u_out (
      .en     (en),
      .cnt    (cnt),
      .period (period),
      .comp   (comp),
      .duty   (duty),
      .out_o  (pwm_out[g*OUT_PER_GRP +: OUT_PER_GRP])
    );
  end

endmodule

// File: tb/pwm_grouped_gen_tb_top.sv
module pwm_grouped_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] pwm_out;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  pwm_grouped_gen dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .pwm_out (pwm_out)
  );

  // Vector: group, period, duty0..3, control, expected high cycles out0..3
  // Control: bit0 enable, bit1 center, bit2 pair0 complement, bit3 pair1 complement.
  localparam int NV = 5;
  localparam int VEC [NV][11] = '{
    '{0, 10, 3, 7, 0, 12,  1,  3,  7,  0, 10},
    '{1,  8, 2, 5, 8,  1,  3,  3,  9, 16,  1},
    '{2,  6, 4, 1, 2,  5, 13,  4,  2,  2,  4},
    '{3,  5, 2, 0, 5,  0,  7,  3,  7, 10,  0},
    '{0,  4, 1, 4, 3,  2, 11,  1,  8,  5,  3}
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input int g, input int sel, input int data);
    wr_en   = 1'b1;
    wr_addr = 5'(g * 8 + sel);
    wr_data = 8'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic setup(input int g, input int per, input int d0, input int d1,
                       input int d2, input int d3, input int ctrl);
    wr(g, 1, 0);
    wr(g, 0, per);
    wr(g, 2, d0);
    wr(g, 3, d1);
    wr(g, 4, d2);
    wr(g, 5, d3);
    wr(g, 1, ctrl);
  endtask

  // Samples n falling edges, counting highs per output of group g and
  // recording the shape of output 0.
  task automatic window(input int g, input int n, output int c[4], output int m0);
    for (int i = 0; i < 4; i++) c[i] = 0;
    m0 = 0;
    for (int k = 0; k < n; k++) begin
      for (int i = 0; i < 4; i++) c[i] += int'(pwm_out[4*g+i]);
      if (pwm_out[4*g]) m0 |= (1 << k);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

  initial begin
    int c[4];
    int m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: all outputs low out of reset
    check("R9 reset outputs", int'(pwm_out), 0);
    repeat (3) @(negedge clk);
    check("R9 idle after reset", int'(pwm_out), 0);

    // Vector table: R1 mapping, R2/R3 alignment, R4 limits, R5/R6 pairing
    for (int v = 0; v < NV; v++) begin
      int len;
      setup(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);
      len = ((VEC[v][6] & 2) != 0) ? 2 * VEC[v][1] : VEC[v][1];
      window(VEC[v][0], len, c, m);
      for (int i = 0; i < 4; i++)
        check($sformatf("R1 R2 R3 R4 R5 R6 vector %0d out %0d", v, i), c[i], VEC[v][7+i]);
    end

    // R2: edge pulse sits at the start of the period
    setup(1, 4, 2, 0, 0, 0, 1);
    window(1, 4, c, m);
    check("R2 edge shape", m, 'b0011);

    // R3: center pulse is symmetric around count 0 (0,1,2,3,4,3,2,1)
    setup(1, 4, 2, 0, 0, 0, 3);
    window(1, 8, c, m);
    check("R3 center shape", m, 'b1000_0011);

    // R7: mid-period duty write waits for the next period
    setup(2, 10, 3, 0, 0, 0, 1);
    window(2, 4, c, m);
    wr(2, 2, 8);
    window(2, 5, c, m);
    check("R7 old duty finishes period", c[0], 0);
    window(2, 10, c, m);
    check("R7 new duty next period", c[0], 8);

    // R8: disabling forces outputs low at once
    wr(3, 1, 0);
    window(3, 6, c, m);
    check("R8 disabled out0", c[0], 0);
    check("R8 disabled out2", c[2], 0);
    check("R8 disabled group bits", int'(pwm_out[15:12]), 0);
    // R8: re-enable starts at count 0 (period 5, duty0 2 kept)
    wr(3, 1, 1);
    window(3, 5, c, m);
    check("R8 restart shape", m, 'b00011);
    check("R4 full duty on restart", c[2], 5);

    $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

endmodule